// File: doc/BRIEF.md
# Serial Slave Shift Front End with Transfer Pause

This block is the bit-level front end of a serial memory slave. It watches an external serial clock, an active-low select and an active-low pause input, all brought into the system clock domain through two-flop synchronizers. Edges are detected on the synchronized copies. Incoming data is sampled on each rising serial-clock edge, most significant bit first. Each completed byte is handed to a command sequencer with a one-cycle strobe.

In the same cycle as that strobe, the block asks the sequencer for the next outgoing byte. It captures that byte on the next falling serial-clock edge and shifts it out MSB first, changing the output only on falling edges. The serial clock may idle low or high, so both clock modes 0 and 3 work.

The pause input suspends a transfer without losing its place. It takes effect only when it falls while the serial clock is low, and it is released only when it rises while the serial clock is low. While paused, serial-clock edges neither count nor shift, and the output is tristated. Deselecting the block clears the bit position and any pause. While deselected, the output stays tristated and the data input is ignored.

Top module: `spi_hold_frontend`

## Requirements
- R1: Each rising serial-clock edge while selected and not paused samples the data input into bit 0 of the receive shifter, moving earlier bits toward bit 7, so the first bit lands in bit 7. After the 8th such edge, `rx_strobe_o` is high for exactly one cycle and `rx_data_o` holds the assembled byte.
- R2: `tx_req_o` pulses for one cycle together with every `rx_strobe_o`. The value on `tx_data_i` is captured on the next falling serial-clock edge. Its bit 7 is driven on `ser_dout_o` first, and each later falling edge presents the next lower bit. The output changes only after a falling edge.
- R3: While `sel_n_i` is high, `ser_dout_en_o` is 0, and serial-clock and data activity produces no `rx_strobe_o`.
- R4: In every selection, `ser_dout_en_o` stays 0 until the first falling serial-clock edge that follows the first completed byte.
- R5: A falling `pause_n_i` while the serial clock is low enters pause. While paused, `ser_dout_en_o` is 0, and serial-clock edges neither advance the bit position nor shift data.
- R6: Pause ends only when `pause_n_i` rises while the serial clock is low. A rise while the clock is high does not release it. After release, the transfer resumes at the same bit, on both the input and the output side.
- R7: A falling `pause_n_i` while the serial clock is high is ignored, and the transfer continues with every edge counted.
- R8: Deselection clears the bit position and any pause, whatever point the transfer had reached. The next selection starts a fresh byte.
- R9: Transfers with the serial clock idling high (mode 3) give the same bytes as those with it idling low (mode 0).
- R10: After reset, `ser_dout_en_o`, `rx_strobe_o` and `tx_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | External serial clock, asynchronous |
| sel_n_i | input | 1 | Active-low select, asynchronous |
| ser_din_i | input | 1 | Serial data from the master |
| pause_n_i | input | 1 | Active-low pause, asynchronous |
| ser_dout_o | output | 1 | Serial data to the master |
| ser_dout_en_o | output | 1 | Output enable for `ser_dout_o` (0 = high impedance) |
| rx_data_o | output | 8 | Last received byte |
| rx_strobe_o | output | 1 | One-cycle pulse when a byte has been received |
| tx_req_o | output | 1 | One-cycle request for the next outgoing byte |
| tx_data_i | input | 8 | Next outgoing byte from the sequencer |

## Verification
The assertions check the cycle-level rules on every cycle:
- the strobe is a single pulse that follows a rising edge;
- the output changes only after a falling edge;
- the output is tristated while deselected or paused;
- the bit position is frozen during pause;
- pause is entered and left only with the clock low.

Only the bench scenarios can show that the bytes themselves come out right in both clock modes:
- a byte split by a pause, with clock toggling and a refused high-clock release inside it, reassembles correctly;
- a pause attempt with the clock high loses no bit;
- deselecting mid-byte or mid-pause leaves the next transfer clean.

// File: rtl/spi_hold_fe_pkg.sv
package spi_hold_fe_pkg;
    localparam int unsigned DEF_DATA_W      = 8;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // synchronized level plus its edges in the system clock domain
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } edge_t;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int unsigned   W       = 4,
    parameter int unsigned   STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_fe_edges.sv
module spi_fe_edges
    import spi_hold_fe_pkg::*;
#(
    parameter int unsigned  N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         lvl_i,
    output edge_t [N-1:0]        ev_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign ev_o[i].lvl  = lvl_i[i];
        assign ev_o[i].rise = lvl_i[i] & ~prev_q[i];
        assign ev_o[i].fall = ~lvl_i[i] & prev_q[i];
    end
endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold
    import spi_hold_fe_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  desel_i,
    input  logic  sck_lvl_i,
    input  edge_t pause_ev_i,
    output logic  hold_d_o,
    output logic  hold_q_o
);
    logic hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (desel_i) begin
            hold_d = 1'b0;
        end else if (!hold_q) begin
            // entry only with the serial clock low
            if (pause_ev_i.fall && !pause_ev_i.lvl && !sck_lvl_i) hold_d = 1'b1;
        end else begin
            // release only with the serial clock low
            if (pause_ev_i.rise && !sck_lvl_i) hold_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold_d;
    end

    assign hold_d_o = hold_d;
    assign hold_q_o = hold_q;
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
    import spi_hold_fe_pkg::*;
#(
    parameter int unsigned DATA_W      = DEF_DATA_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              sel_n_i,
    input  logic              ser_din_i,
    input  logic              pause_n_i,
    output logic              ser_dout_o,
    output logic              ser_dout_en_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_strobe_o,
    output logic              tx_req_o,
    input  logic [DATA_W-1:0] tx_data_i
);
    localparam int unsigned CNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam int unsigned IDX_DIN  = 0;
    localparam int unsigned IDX_SCK  = 1;
    localparam int unsigned IDX_SEL  = 2;
    localparam int unsigned IDX_PAU  = 3;
    localparam int unsigned NSIG     = 4;

    typedef struct packed {
        logic [DATA_W-1:0] rx_sr;
        logic [DATA_W-1:0] rx_byte;
        logic [CNT_W-1:0]  bit_cnt;
        logic [DATA_W-1:0] tx_sr;
        logic              tx_pend;
        logic              out_act;
        logic              oe;
        logic              rx_vld;
        logic              tx_req;
    } core_t;

    logic [NSIG-1:0] raw_w, sync_w;
    edge_t [2:0]     ev_w;
    edge_t           sck_ev, cs_ev, pause_ev;
    logic            din_s;
    logic            hold_d, hold_q;
    logic            desel;
    core_t           d, q;
    logic [CNT_W-1:0] bit_cnt_w;

    assign raw_w[IDX_DIN] = ser_din_i;
    assign raw_w[IDX_SCK] = ser_clk_i;
    assign raw_w[IDX_SEL] = sel_n_i;
    assign raw_w[IDX_PAU] = pause_n_i;

    spi_fe_sync #(
        .W      (NSIG),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b1100)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_w),
        .sync_o (sync_w)
    );

    spi_fe_edges #(
        .N      (3),
        .RST_VAL(3'b110)
    ) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl_i(sync_w[IDX_PAU:IDX_SCK]),
        .ev_o (ev_w)
    );

    assign din_s    = sync_w[IDX_DIN];
    assign sck_ev   = ev_w[0];
    assign cs_ev    = ev_w[1];
    assign pause_ev = ev_w[2];
    assign desel    = cs_ev.lvl | cs_ev.rise | cs_ev.fall;

    spi_fe_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .desel_i   (desel),
        .sck_lvl_i (sck_ev.lvl),
        .pause_ev_i(pause_ev),
        .hold_d_o  (hold_d),
        .hold_q_o  (hold_q)
    );

    always_comb begin
        d        = q;
        d.rx_vld = 1'b0;
        d.tx_req = 1'b0;
        if (desel) begin
            d.bit_cnt = '0;
            d.tx_pend = 1'b0;
            d.out_act = 1'b0;
        end else if (!hold_q) begin
            if (sck_ev.rise) begin
                d.rx_sr = {q.rx_sr[DATA_W-2:0], din_s};
                if (q.bit_cnt == LAST_BIT) begin
                    d.bit_cnt = '0;
                    d.rx_byte = {q.rx_sr[DATA_W-2:0], din_s};
                    d.rx_vld  = 1'b1;
                    d.tx_req  = 1'b1;
                    d.tx_pend = 1'b1;
                end else begin
                    d.bit_cnt = q.bit_cnt + 1'b1;
                end
            end
            if (sck_ev.fall) begin
                if (q.tx_pend) begin
                    d.tx_sr   = tx_data_i;
                    d.tx_pend = 1'b0;
                    d.out_act = 1'b1;
                end else begin
                    d.tx_sr = {q.tx_sr[DATA_W-2:0], 1'b0};
                end
            end
        end
        d.oe = !cs_ev.lvl && !hold_d && d.out_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ser_dout_o    = q.tx_sr[DATA_W-1];
    assign ser_dout_en_o = q.oe;
    assign rx_data_o     = q.rx_byte;
    assign rx_strobe_o   = q.rx_vld;
    assign tx_req_o      = q.tx_req;
    assign bit_cnt_w     = q.bit_cnt;
endmodule

// File: rtl/spi_hold_fe_chk.sv
module spi_hold_fe_chk
    import spi_hold_fe_pkg::*;
#(
    parameter int unsigned CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input edge_t            sck_ev,
    input edge_t            cs_ev,
    input edge_t            pause_ev,
    input logic             hold_q,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             so,
    input logic             so_oe,
    input logic             rx_strobe,
    input logic             tx_req
);
    a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);

    a_r1_strobe_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> $past(sck_ev.rise));

    a_r2_req_pairs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> rx_strobe);

    a_r2_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && (so != $past(so))) |-> $past(sck_ev.fall));

    a_r3_desel_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        cs_ev.lvl |=> !so_oe);

    a_r4_oe_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> $past(sck_ev.fall || pause_ev.rise));

    a_r5_hold_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> !so_oe);

    a_r5_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !cs_ev.lvl) |=> $stable(bit_cnt));

    a_r7_entry_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_q) |-> $past(pause_ev.fall && !sck_ev.lvl));

    a_r6_exit_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_q) |-> $past(cs_ev.lvl || cs_ev.rise || (pause_ev.rise && !sck_ev.lvl)));
endmodule

bind spi_hold_frontend spi_hold_fe_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_ev   (sck_ev),
    .cs_ev    (cs_ev),
    .pause_ev (pause_ev),
    .hold_q   (hold_q),
    .bit_cnt  (bit_cnt_w),
    .so       (ser_dout_o),
    .so_oe    (ser_dout_en_o),
    .rx_strobe(rx_strobe_o),
    .tx_req   (tx_req_o)
);

// File: tb/spi_hold_frontend_test.sv
module spi_hold_frontend_test;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b1, si = 1'b0, holdn = 1'b1;
    logic so, so_oe, rx_strobe, tx_req;
    logic [7:0] rx_data, tx_data = 8'h00;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [7:0] tx_vals [256];
    int tx_idx = 0;
    logic [7:0] rx_log [256];
    int rx_cnt = 0;
    int tx_base, rx_base;
    logic [7:0] mosi [8];

    always #2.5 clk = ~clk;

    spi_hold_frontend uut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sck), .sel_n_i(csn),
        .ser_din_i(si), .pause_n_i(holdn), .ser_dout_o(so),
        .ser_dout_en_o(so_oe), .rx_data_o(rx_data), .rx_strobe_o(rx_strobe),
        .tx_req_o(tx_req), .tx_data_i(tx_data)
    );

    // sequencer model: fresh byte per request
    always @(negedge clk) begin
        if (tx_req) begin
            tx_data = tx_vals[tx_idx % 256];
            tx_idx++;
        end
        if (rx_strobe) begin
            rx_log[rx_cnt % 256] = rx_data;
            rx_cnt++;
        end
    end

    function automatic logic [7:0] exp_tx(input int k);
        return tx_vals[k % 256];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic xfer_bit(input logic b, output logic so_b, output logic oe_b);
        sck = 1'b0; si = b; half();
        so_b = so; oe_b = so_oe;
        sck = 1'b1; half();
    endtask

    task automatic run_byte(input logic [7:0] mo, output logic [7:0] mi,
                            output logic oe_all, output logic oe_any);
        logic sb, ob;
        oe_all = 1'b1; oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(mo[i], sb, ob);
            mi[i] = sb; oe_all &= ob; oe_any |= ob;
        end
    endtask

    task automatic txn_open(input bit mode3);
        sck = mode3; half();
        csn = 1'b0; half();
        tx_base = tx_idx; rx_base = rx_cnt;
    endtask

    task automatic txn_close(input bit mode3, input int n, input string req);
        if (!mode3) sck = 1'b0;
        half(); csn = 1'b1; half(); half();
        check(rx_cnt - rx_base == n, req, rx_cnt - rx_base, n);
        for (int k = 0; k < n; k++)
            check(rx_log[(rx_base + k) % 256] == mosi[k], req,
                  rx_log[(rx_base + k) % 256], mosi[k]);
        check(tx_idx - tx_base == n, "R2 request count", tx_idx - tx_base, n);
        check(so_oe == 1'b0, "R3 tristate after deselect", so_oe, 0);
    endtask

    task automatic run_txn(input bit mode3, input int n, input string req);
        logic [7:0] mi; logic oa, on;
        for (int k = 0; k < n; k++) mosi[k] = 8'($urandom);
        txn_open(mode3);
        for (int k = 0; k < n; k++) begin
            run_byte(mosi[k], mi, oa, on);
            if (k == 0) check(on == 1'b0, "R4 no drive in first byte", on, 0);
            else begin
                check(oa == 1'b1, "R2 drive during reply", oa, 1);
                check(mi == exp_tx(tx_base + k - 1), "R2 reply bits", mi, exp_tx(tx_base + k - 1));
            end
        end
        txn_close(mode3, n, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] mi; logic oa, on, sb, ob;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 256; i++) tx_vals[i] = 8'($urandom);
        repeat (4) @(negedge clk);
        check(so_oe == 0 && rx_strobe == 0 && tx_req == 0, "R10 reset outputs",
              {so_oe, rx_strobe, tx_req}, 0);
        rst_n = 1'b1;
        half();

        // R3: activity while deselected
        rx_base = rx_cnt;
        for (int i = 0; i < 16; i++) begin
            sck = ~sck; si = 1'($urandom); half();
            check(so_oe == 0, "R3 tristate while deselected", so_oe, 0);
        end
        sck = 1'b0; half();
        check(rx_cnt == rx_base, "R3 no strobe while deselected", rx_cnt - rx_base, 0);

        // R1 directed pattern, R9 directed mode 3
        run_txn(1'b0, 3, "R1 mode0 bytes");
        run_txn(1'b1, 3, "R9 mode3 bytes");

        // R5/R6: pause mid-byte with toggling and refused high release
        mosi[0] = 8'h3C; mosi[1] = 8'hA7;
        txn_open(1'b0);
        run_byte(mosi[0], mi, oa, on);
        for (int i = 7; i >= 5; i--) begin xfer_bit(mosi[1][i], sb, ob); mi[i] = sb; end
        sck = 1'b0; half();
        holdn = 1'b0; half(); half();
        check(so_oe == 0, "R5 tristate in pause", so_oe, 0);
        for (int i = 0; i < 3; i++) begin
            sck = 1'b1; si = 1'($urandom); half();
            check(so_oe == 0, "R5 tristate while clock toggles", so_oe, 0);
            sck = 1'b0; half();
        end
        sck = 1'b1; half();
        holdn = 1'b1; half(); half();
        check(so_oe == 0, "R6 rise with clock high keeps pause", so_oe, 0);
        sck = 1'b0; half();
        holdn = 1'b0; half();
        holdn = 1'b1; half(); half();
        check(so_oe == 1, "R6 release with clock low", so_oe, 1);
        for (int i = 4; i >= 0; i--) begin xfer_bit(mosi[1][i], sb, ob); mi[i] = sb; end
        check(mi == exp_tx(tx_base), "R6 reply resumes at same bit", mi, exp_tx(tx_base));
        txn_close(1'b0, 2, "R5 byte intact across pause");

        // R7: pause falling with clock high is ignored
        mosi[0] = 8'h81; mosi[1] = 8'h5B;
        txn_open(1'b0);
        run_byte(mosi[0], mi, oa, on);
        for (int i = 7; i >= 4; i--) begin xfer_bit(mosi[1][i], sb, ob); mi[i] = sb; end
        holdn = 1'b0; half();
        oa = 1'b1;
        for (int i = 3; i >= 0; i--) begin xfer_bit(mosi[1][i], sb, ob); mi[i] = sb; oa &= ob; end
        check(oa == 1, "R7 drive continues", oa, 1);
        check(mi == exp_tx(tx_base), "R7 reply intact", mi, exp_tx(tx_base));
        txn_close(1'b0, 2, "R7 all bits counted");
        holdn = 1'b1; half();

        // R8: deselect mid-byte
        mosi[0] = 8'hE2;
        txn_open(1'b0);
        run_byte(mosi[0], mi, oa, on);
        for (int i = 0; i < 5; i++) xfer_bit(1'b1, sb, ob);
        txn_close(1'b0, 1, "R8 partial byte dropped");
        run_txn(1'b0, 2, "R8 fresh byte after abort");

        // R8: deselect while paused, pause released only by deselect
        mosi[0] = 8'h17;
        txn_open(1'b0);
        run_byte(mosi[0], mi, oa, on);
        xfer_bit(1'b0, sb, ob); xfer_bit(1'b1, sb, ob);
        sck = 1'b0; half();
        holdn = 1'b0; half(); half();
        check(so_oe == 0, "R5 paused before deselect", so_oe, 0);
        sck = 1'b1; half();
        csn = 1'b1; half(); half();
        holdn = 1'b1; half();
        sck = 1'b0; half();
        check(so_oe == 0, "R3 tristate after deselect", so_oe, 0);
        run_txn(1'b0, 2, "R8 pause cleared by deselect");

        // random mix of modes and lengths
        for (int t = 0; t < 20; t++)
            run_txn(1'($urandom), 1 + int'($urandom % 4), "R1 R9 random transfer");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule